// File: doc/BRIEF.md
# External Memory Bus Cycle Controller

This block sits between the core's memory request port and the chip's external bus pins. When a request arrives, the block decodes its 24-bit address into one of three 1 MB chip-enable windows. If the address hits a window, the block runs a four-phase bus cycle on a 20-bit address bus, an 8-bit data bus, active-low read and write strobes and three active-low chip enables. Addresses that fall on internal memory, or outside every window, finish in one cycle and touch no pin. The window map depends on a mode input: in the internal-boot map the windows sit at 100000h–3FFFFFh. In the external-boot map the low window also covers the boot space, but never the internal block 00D800h–00FFFFh.

Each bus phase lasts one period of `clk`, which is the half-period state clock of the core. A programmable number of extra phases (twice a 3-bit setting) is inserted between the third and fourth phase. No extra phases are inserted while the core runs from its slow clock. Each chip-enable pin can be handed back to a port register bit on its own. In single-chip operation every bus pin is driven from the port registers and no external cycle is run. While the chip is in standby, every chip-enable pin in bus function is forced inactive and no new request is taken.

The state machine has seven states. IDLE waits for a request. INT completes an internal access. T1 is the address phase. T2 and T3 are the strobe phases. TW holds the inserted wait phases. T4 is the release and completion phase. The transitions are:
- IDLE→T1 on an accepted external request, and IDLE→INT on an accepted internal request.
- INT→IDLE.
- T1→T2→T3.
- T3→T4 when the wait count is zero, and T3→TW otherwise.
- TW→TW until the last wait phase, then TW→T4.
- T4→IDLE.

Top module: `ext_bus_ctl`

## Requirements
- R1: After reset the state is IDLE. `req_ready` is 1, `cyc_done` and `cyc_rdata` are 0. In expansion mode, `bus_rd_n`, `bus_wr_n` and every chip-enable pin in bus function are 1, and `bus_doe` is 0.
- R2: An external access runs T1, T2, T3, any wait phases, then T4, each one clock long. `cyc_done` is a single-cycle pulse in T4. The read or write strobe is low from T2 to the last phase before T4, and the two strobes are never low together.
- R3: The number of wait phases inserted between T3 and T4 is 2×`wait_sel` (0 to 14), latched when the request is accepted. It is 0 when `slow_clk` is 1. An external access therefore takes 4+2N cycles from acceptance to `cyc_done`.
- R4: With `mpu_mode`=0, address windows 100000h–1FFFFFh, 200000h–2FFFFFh and 300000h–3FFFFFh assert chip enable 0, 1 and 2 (`bus_ce_n` bit 0, 1, 2) from T1 to T4. At most one chip enable is low at a time.
- R5: With `mpu_mode`=1, chip enable 0 covers 000000h–00D7FFh and 010000h–0FFFFFh. Chip enable 1 covers 100000h–1FFFFFh and chip enable 2 covers 200000h–2FFFFFh.
- R6: Accesses to 00D800h–00FFFFh, to addresses outside every window, or to anything in single-chip mode, assert no strobe and no chip enable. They raise `cyc_done` in the cycle after acceptance, with `cyc_rdata`=0.
- R7: For a read, `bus_din` is captured at the end of the last phase before T4 and presented on `cyc_rdata` with `cyc_done`. Writes return 0.
- R8: `bus_doe` is all ones, with `bus_dout` equal to the write data, from T2 to T4 of a write only. It is 0 in every read cycle.
- R9: A chip-enable pin whose `ce_func` bit is 0 follows its `port_ce` bit at all times, including during accesses to its window.
- R10: With `expand_mode`=0, `bus_addr`, `bus_rd_n`, `bus_wr_n`, `bus_ce_n`, `bus_dout` and `bus_doe` equal `port_addr`, `port_rd`, `port_wr`, `port_ce`, `port_dout` and `port_doe`.
- R11: While `standby` is 1, `req_ready` is 0 and every chip-enable pin in bus function is 1, even in the middle of a cycle.
- R12: From T2 to the last strobe phase, `bus_addr` carries bits 19:0 of the accepted address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus state clock (one bus phase per period) |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core presents a memory request |
| req_ready | output | 1 | Request is taken on this edge when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Core address |
| req_wdata | input | 8 | Write data |
| cyc_done | output | 1 | Access complete pulse |
| cyc_rdata | output | 8 | Read data, valid with `cyc_done` |
| mpu_mode | input | 1 | 1 = external-boot window map |
| expand_mode | input | 1 | 1 = expansion bus, 0 = single-chip port use |
| slow_clk | input | 1 | Core runs from slow clock; suppresses waits |
| standby | input | 1 | Chip in standby |
| wait_sel | input | 3 | Wait setting; 2×value phases |
| ce_func | input | 3 | Per pin: 1 = chip enable, 0 = port output |
| port_addr | input | 20 | Port register driving address pins |
| port_rd | input | 1 | Port register driving read pin |
| port_wr | input | 1 | Port register driving write pin |
| port_ce | input | 3 | Port register driving chip-enable pins |
| port_dout | input | 8 | Port data for data pins |
| port_doe | input | 8 | Port output enables for data pins |
| bus_addr | output | 20 | Address pins |
| bus_rd_n | output | 1 | Read strobe pin, active low |
| bus_wr_n | output | 1 | Write strobe pin, active low |
| bus_ce_n | output | 3 | Chip-enable pins, active low |
| bus_dout | output | 8 | Data pin output value |
| bus_doe | output | 8 | Data pin output enables |
| bus_din | input | 8 | Data pin input value |

## Verification
The assertions assume that the core holds `mpu_mode`, `expand_mode`, `ce_func` and `wait_sel` steady while a cycle is in flight. They also assume that `standby` rises only when the core has stopped issuing requests. The bench changes those inputs only while the queue of expected completions is empty. The one exception is a deliberate mid-cycle standby pulse that checks the forced chip-enable release. `bus_din` is set before each request and held until the request completes, so the captured byte is defined at the sampling edge.

// File: rtl/ebc_pkg.sv
`timescale 1ns/1ps
package ebc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INT,
        ST_T1,
        ST_T2,
        ST_T3,
        ST_TW,
        ST_T4
    } ebc_state_e;
endpackage

// File: rtl/ebc_decode.sv
`timescale 1ns/1ps
module ebc_decode #(
    parameter int          AW       = 24,
    parameter int          WIN_W    = 20,
    parameter int          NUM_CE   = 3,
    parameter logic [15:0] LOCAL_LO = 16'hD800
) (
    input  logic [AW-1:0]     addr,
    input  logic              mpu_mode,
    output logic [NUM_CE-1:0] ce_hit
);
    localparam int TAG_W = AW - WIN_W;

    logic [TAG_W-1:0] win;
    logic             local_blk;

    assign win       = addr[AW-1:WIN_W];
    // RAM, display and I/O block in the first 64 KB stay on chip
    assign local_blk = (addr[WIN_W-1:16] == '0) && (addr[15:0] >= LOCAL_LO);

    for (genvar i = 0; i < NUM_CE; i++) begin : g_win
        if (i == 0) begin : g_low
            assign ce_hit[i] = mpu_mode ? ((win == TAG_W'(0)) && !local_blk)
                                        : (win == TAG_W'(1));
        end else begin : g_high
            assign ce_hit[i] = mpu_mode ? (win == TAG_W'(i))
                                        : (win == TAG_W'(i + 1));
        end
    end
endmodule

// File: rtl/ebc_seq.sv
`timescale 1ns/1ps
module ebc_seq
    import ebc_pkg::*;
#(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ext,
    input  logic [WAIT_W-1:0] wait_sel,
    input  logic              slow_clk,
    output ebc_state_e        state_q,
    output logic              frame_on,
    output logic              strobe_on,
    output logic              drive_on,
    output logic              sample,
    output logic              done
);
    localparam int CNT_W = WAIT_W + 1;

    ebc_state_e       state_d;
    logic [CNT_W-1:0] wcnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ext ? ST_T1 : ST_INT;
            ST_INT:  state_d = ST_IDLE;
            ST_T1:   state_d = ST_T2;
            ST_T2:   state_d = ST_T3;
            ST_T3:   state_d = (wcnt_q == '0) ? ST_T4 : ST_TW;
            ST_TW:   state_d = (wcnt_q == CNT_W'(1)) ? ST_T4 : ST_TW;
            ST_T4:   state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt_q <= '0;
        end else if (state_q == ST_IDLE && start) begin
            wcnt_q <= slow_clk ? '0 : {wait_sel, 1'b0};
        end else if (state_q == ST_TW) begin
            wcnt_q <= wcnt_q - CNT_W'(1);
        end
    end

    always_comb begin
        frame_on  = 1'b0;
        strobe_on = 1'b0;
        drive_on  = 1'b0;
        sample    = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_INT:  done = 1'b1;
            ST_T1:   frame_on = 1'b1;
            ST_T2: begin
                frame_on  = 1'b1;
                strobe_on = 1'b1;
                drive_on  = 1'b1;
            end
            ST_T3: begin
                frame_on  = 1'b1;
                strobe_on = 1'b1;
                drive_on  = 1'b1;
                sample    = (wcnt_q == '0);
            end
            ST_TW: begin
                frame_on  = 1'b1;
                strobe_on = 1'b1;
                drive_on  = 1'b1;
                sample    = (wcnt_q == CNT_W'(1));
            end
            ST_T4: begin
                frame_on = 1'b1;
                drive_on = 1'b1;
                done     = 1'b1;
            end
            default: ;
        endcase
    end

    AST_T1_THEN_T2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_T1 |=> state_q == ST_T2); // R2
    AST_WAIT_AFTER_T3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_TW |-> ($past(state_q) == ST_T3 || $past(state_q) == ST_TW)); // R3
    AST_T4_FROM_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_T4 |-> ($past(state_q) == ST_T3 || $past(state_q) == ST_TW)); // R2
endmodule

// File: rtl/ext_bus_ctl.sv
`timescale 1ns/1ps
module ext_bus_ctl
    import ebc_pkg::*;
#(
    parameter int CPU_AW = 24,
    parameter int BUS_AW = 20,
    parameter int DW     = 8,
    parameter int NUM_CE = 3,
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [CPU_AW-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    output logic              cyc_done,
    output logic [DW-1:0]     cyc_rdata,
    input  logic              mpu_mode,
    input  logic              expand_mode,
    input  logic              slow_clk,
    input  logic              standby,
    input  logic [WAIT_W-1:0] wait_sel,
    input  logic [NUM_CE-1:0] ce_func,
    input  logic [BUS_AW-1:0] port_addr,
    input  logic              port_rd,
    input  logic              port_wr,
    input  logic [NUM_CE-1:0] port_ce,
    input  logic [DW-1:0]     port_dout,
    input  logic [DW-1:0]     port_doe,
    output logic [BUS_AW-1:0] bus_addr,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [NUM_CE-1:0] bus_ce_n,
    output logic [DW-1:0]     bus_dout,
    output logic [DW-1:0]     bus_doe,
    input  logic [DW-1:0]     bus_din
);
    ebc_state_e        state_q;
    logic [NUM_CE-1:0] ce_hit;
    logic              accept;
    logic              ext_req;
    logic              frame_on;
    logic              strobe_on;
    logic              drive_on;
    logic              sample;

    logic [BUS_AW-1:0] addr_q;
    logic [DW-1:0]     wdata_q;
    logic              write_q;
    logic [NUM_CE-1:0] sel_q;
    logic [DW-1:0]     rdata_q;

    ebc_decode #(
        .AW     (CPU_AW),
        .WIN_W  (BUS_AW),
        .NUM_CE (NUM_CE)
    ) u_decode (
        .addr     (req_addr),
        .mpu_mode (mpu_mode),
        .ce_hit   (ce_hit)
    );

    assign req_ready = (state_q == ST_IDLE) && !standby;
    assign accept    = req_valid && req_ready;
    assign ext_req   = expand_mode && (ce_hit != '0);

    ebc_seq #(
        .WAIT_W (WAIT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .ext       (ext_req),
        .wait_sel  (wait_sel),
        .slow_clk  (slow_clk),
        .state_q   (state_q),
        .frame_on  (frame_on),
        .strobe_on (strobe_on),
        .drive_on  (drive_on),
        .sample    (sample),
        .done      (cyc_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            sel_q   <= '0;
        end else if (accept) begin
            addr_q  <= req_addr[BUS_AW-1:0];
            wdata_q <= req_wdata;
            write_q <= req_write;
            sel_q   <= ext_req ? ce_hit : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rdata_q <= '0;
        else if (accept)           rdata_q <= '0;
        else if (sample && !write_q) rdata_q <= bus_din;
    end

    assign cyc_rdata = rdata_q;

    always_comb begin
        bus_addr = port_addr;
        bus_rd_n = port_rd;
        bus_wr_n = port_wr;
        bus_ce_n = port_ce;
        bus_dout = port_dout;
        bus_doe  = port_doe;
        if (expand_mode) begin
            bus_addr = addr_q;
            bus_rd_n = !(strobe_on && !write_q);
            bus_wr_n = !(strobe_on && write_q);
            bus_dout = wdata_q;
            bus_doe  = (drive_on && write_q) ? '1 : '0;
            for (int i = 0; i < NUM_CE; i++) begin
                if (ce_func[i]) bus_ce_n[i] = !(sel_q[i] && frame_on && !standby);
            end
        end
    end

    AST_ONE_CE: assert property (@(posedge clk) disable iff (!rst_n)
        expand_mode |-> $countones(~bus_ce_n & ce_func) <= 1); // R4
    AST_STANDBY_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (expand_mode && standby) |-> ((bus_ce_n & ce_func) == ce_func)); // R11
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        expand_mode |-> (bus_rd_n || bus_wr_n)); // R2
    AST_DOE_NOT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (expand_mode && bus_doe != '0) |-> bus_rd_n); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_done |=> !cyc_done); // R2
    AST_CE_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (expand_mode && !bus_rd_n && !$rose(!bus_rd_n)) |-> $stable(bus_addr)); // R12
endmodule

// File: tb/ext_bus_ctl_test.sv
`timescale 1ns/1ps
module ext_bus_ctl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready, req_write;
    logic [23:0] req_addr;
    logic [7:0]  req_wdata;
    logic        cyc_done;
    logic [7:0]  cyc_rdata;
    logic        mpu_mode, expand_mode, slow_clk, standby;
    logic [2:0]  wait_sel, ce_func, port_ce, bus_ce_n;
    logic [19:0] port_addr, bus_addr;
    logic        port_rd, port_wr, bus_rd_n, bus_wr_n;
    logic [7:0]  port_dout, port_doe, bus_dout, bus_doe, bus_din;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    ext_bus_ctl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .cyc_done(cyc_done), .cyc_rdata(cyc_rdata), .mpu_mode(mpu_mode),
        .expand_mode(expand_mode), .slow_clk(slow_clk), .standby(standby),
        .wait_sel(wait_sel), .ce_func(ce_func), .port_addr(port_addr),
        .port_rd(port_rd), .port_wr(port_wr), .port_ce(port_ce),
        .port_dout(port_dout), .port_doe(port_doe), .bus_addr(bus_addr),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_ce_n(bus_ce_n),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din)
    );

    typedef struct {
        logic [7:0]  rdata;
        logic [2:0]  ce_and;
        int          cycles;
        int          strobes;
        logic [19:0] a20;
        logic [7:0]  wd;
    } exp_t;

    exp_t  sq[$];
    string tq[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: computes the expected outcome from the requirements and queues it
    task automatic issue(input logic [23:0] a, input bit w, input logic [7:0] wd,
                         input logic [7:0] din, input bit ext, input logic [2:0] sel,
                         input string tag);
        exp_t e;
        int   n;
        n         = slow_clk ? 0 : 2 * int'(wait_sel);
        e.cycles  = ext ? 4 + n : 1;
        e.strobes = ext ? 2 + n : 0;
        e.rdata   = (ext && !w) ? din : 8'h00;
        e.a20     = a[19:0];
        e.wd      = wd;
        for (int i = 0; i < 3; i++)
            e.ce_and[i] = (!expand_mode || !ce_func[i]) ? port_ce[i] : !sel[i];
        do @(negedge clk); while (!req_ready);
        bus_din   = din;
        req_addr  = a;
        req_write = w;
        req_wdata = wd;
        req_valid = 1'b1;
        @(posedge clk);
        sq.push_back(e);
        tq.push_back(tag);
        #1 req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do begin
            @(negedge clk);
            #1;
        end while (sq.size() != 0);
    endtask

    // Monitor: accumulates pin activity per access and compares on completion
    int         m_cyc = 0, m_strb = 0;
    logic [2:0] m_ce = 3'b111;
    bit         m_abad = 0, m_dbad = 0;
    exp_t       m_e;
    string      m_t;

    always @(negedge clk) begin
        if (sq.size() > 0) begin
            m_e = sq[0];
            m_cyc++;
            m_ce = m_ce & bus_ce_n;
            if (expand_mode) begin
                if (!bus_rd_n || !bus_wr_n) begin
                    m_strb++;
                    if (bus_addr != m_e.a20) m_abad = 1;
                end
                if (!bus_wr_n && (bus_doe != 8'hFF || bus_dout != m_e.wd)) m_dbad = 1;
                if (!bus_rd_n && bus_doe != 8'h00) m_dbad = 1;
            end
            if (cyc_done) begin
                m_t = tq[0];
                chk(m_cyc == m_e.cycles, {m_t, " R2/R3 cycle length"}, m_cyc, m_e.cycles);
                chk(m_strb == m_e.strobes, {m_t, " R2 strobe phases"}, m_strb, m_e.strobes);
                chk(m_ce == m_e.ce_and, {m_t, " R4/R5/R9 chip enables"}, m_ce, m_e.ce_and);
                chk(cyc_rdata == m_e.rdata, {m_t, " R7 read data"}, cyc_rdata, m_e.rdata);
                chk(!m_abad, {m_t, " R12 address pins"}, m_abad, 0);
                chk(!m_dbad, {m_t, " R8 data drive"}, m_dbad, 0);
                void'(sq.pop_front());
                void'(tq.pop_front());
                m_cyc = 0; m_strb = 0; m_ce = 3'b111; m_abad = 0; m_dbad = 0;
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
        mpu_mode = 0; expand_mode = 1; slow_clk = 0; standby = 0; wait_sel = 0;
        ce_func = 3'b111; port_addr = 20'hA5A5A; port_rd = 1; port_wr = 0;
        port_ce = 3'b010; port_dout = 8'h3C; port_doe = 8'hF0; bus_din = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(bus_ce_n == 3'b111, "R1 ce idle", bus_ce_n, 3'b111);
        chk(bus_rd_n && bus_wr_n, "R1 strobes idle", {bus_rd_n, bus_wr_n}, 2'b11);
        chk(!cyc_done && cyc_rdata == 0, "R1 done/rdata", {cyc_done, cyc_rdata}, 0);
        chk(bus_doe == 0, "R1 doe", bus_doe, 0);
        chk(req_ready, "R1 ready", req_ready, 1);

        // R4 internal-boot map
        issue(24'h100010, 0, 8'h00, 8'h5A, 1, 3'b001, "R4 ce0");
        issue(24'h2ABCDE, 0, 8'h00, 8'hC3, 1, 3'b010, "R4 ce1");
        issue(24'h3FFFFF, 0, 8'h00, 8'h81, 1, 3'b100, "R7 ce2 read");
        // R6 internal and unmapped
        issue(24'h00D800, 0, 8'h00, 8'hEE, 0, 3'b000, "R6 ram");
        issue(24'h0EFFFF, 0, 8'h00, 8'hEE, 0, 3'b000, "R6 font");
        issue(24'h000000, 1, 8'h11, 8'hEE, 0, 3'b000, "R6 rom");
        issue(24'h400000, 0, 8'h00, 8'hEE, 0, 3'b000, "R6 beyond");
        wait_idle();
        // R3 wait phases
        wait_sel = 3'd1; issue(24'h150000, 0, 8'h00, 8'h12, 1, 3'b001, "R3 wait1");
        wait_idle(); wait_sel = 3'd3; issue(24'h350123, 0, 8'h00, 8'h34, 1, 3'b100, "R3 wait3");
        wait_idle(); wait_sel = 3'd7; issue(24'h250000, 1, 8'h96, 8'h00, 1, 3'b010, "R8 write wait7");
        wait_idle(); slow_clk = 1; issue(24'h250001, 0, 8'h00, 8'h77, 1, 3'b010, "R3 slow clock");
        wait_idle(); slow_clk = 0; wait_sel = 3'd0;
        issue(24'h3000AA, 1, 8'h69, 8'h00, 1, 3'b100, "R8 write");
        wait_idle();

        // R5 external-boot map
        mpu_mode = 1;
        issue(24'h000000, 0, 8'h00, 8'h01, 1, 3'b001, "R5 boot");
        issue(24'h00D7FF, 0, 8'h00, 8'h02, 1, 3'b001, "R5 below ram");
        issue(24'h00D800, 0, 8'h00, 8'h03, 0, 3'b000, "R5 ram");
        issue(24'h00FFFF, 0, 8'h00, 8'h04, 0, 3'b000, "R5 io");
        issue(24'h010000, 0, 8'h00, 8'h05, 1, 3'b001, "R5 low page");
        issue(24'h0FFFFF, 1, 8'hA7, 8'h00, 1, 3'b001, "R5 low top");
        issue(24'h1ABCDE, 0, 8'h00, 8'h06, 1, 3'b010, "R5 ce1");
        issue(24'h2FFFFF, 0, 8'h00, 8'h07, 1, 3'b100, "R5 ce2");
        issue(24'h300000, 0, 8'h00, 8'h08, 0, 3'b000, "R5 unmapped");
        issue(24'hC00000, 0, 8'h00, 8'h09, 0, 3'b000, "R5 high");
        wait_idle();
        mpu_mode = 0;

        // R9 per-pin fallback
        ce_func = 3'b101; port_ce = 3'b000;
        @(negedge clk);
        chk(bus_ce_n == 3'b010 ^ 3'b111, "R9 idle pins", bus_ce_n, 3'b101);
        issue(24'h200040, 0, 8'h00, 8'h44, 1, 3'b010, "R9 ce1 as port");
        issue(24'h100040, 0, 8'h00, 8'h45, 1, 3'b001, "R9 ce0 bus");
        wait_idle();
        ce_func = 3'b111; port_ce = 3'b010;

        // R10 single-chip mode
        expand_mode = 0;
        @(negedge clk);
        chk(bus_addr == port_addr, "R10 addr pins", bus_addr, port_addr);
        chk({bus_rd_n, bus_wr_n} == {port_rd, port_wr}, "R10 strobe pins", {bus_rd_n, bus_wr_n}, {port_rd, port_wr});
        chk(bus_ce_n == port_ce, "R10 ce pins", bus_ce_n, port_ce);
        chk(bus_dout == port_dout && bus_doe == port_doe, "R10 data pins", {bus_dout, bus_doe}, {port_dout, port_doe});
        issue(24'h100000, 0, 8'h00, 8'h55, 0, 3'b000, "R10 internal in single chip");
        wait_idle();
        expand_mode = 1;

        // R11 standby
        standby = 1;
        @(negedge clk);
        chk(!req_ready, "R11 no accept", req_ready, 0);
        repeat (3) @(negedge clk);
        chk(!req_ready && sq.size() == 0, "R11 still idle", req_ready, 0);
        standby = 0;
        wait_sel = 3'd7;
        issue(24'h200000, 0, 8'h00, 8'h66, 1, 3'b010, "R11 cycle");
        repeat (3) @(negedge clk);
        standby = 1;
        @(negedge clk);
        chk(bus_ce_n == 3'b111, "R11 ce forced off", bus_ce_n, 3'b111);
        standby = 0;
        @(negedge clk);
        chk(bus_ce_n == 3'b101, "R11 ce restored", bus_ce_n, 3'b101);
        wait_idle();

        finish_run();
    end
endmodule